// File: doc/BRIEF.md
# Global history branch direction predictor

This block guesses whether a conditional branch will be taken from the outcomes of the most recent branches alone. A shift register of `HIST_W` bits holds the latest outcomes, with taken recorded as 1 and not taken as 0. Its value selects one of `2^HIST_W` two-bit saturating counters. The upper bit of the selected counter is the guess. The branch address plays no part in the lookup. Every branch in the program shares the same history and the same table.

The fetch side raises a request and receives the direction one cycle later. Once the branch resolves, the execute side pulses a resolve strobe carrying the real outcome. Two things then happen. The counter chosen at prediction time moves one step toward that outcome. The outcome enters the history at its least significant bit, and the oldest bit is dropped. Requests and resolves must alternate one to one. At most one prediction can be waiting for its resolve. A request made while one is waiting, or a resolve made while none is waiting, is dropped.

Top module: `ghist_dir_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 2'b10, so the first prediction is taken and `history_o` reads 0.
- R2: A request accepted in cycle t (`pred_req_i` high with nothing waiting) makes `pred_valid_o` high in cycle t+1 only. `pred_valid_o` is never high in two consecutive cycles.
- R3: Each counter counts up on a taken resolve and down on a not-taken resolve. It saturates at 2'b11 and at 2'b00 and never wraps. It predicts taken in states 2'b10 and 2'b11.
- R4: An accepted resolve shifts its outcome into bit 0 of the history and drops the top bit. Starting from 0000, two taken resolves give 0001 and then 0011.
- R5: `pred_taken_o` equals the upper bit of the counter indexed by the history at the moment the request was accepted.
- R6: A request made while a prediction is waiting for its resolve is ignored. No `pred_valid_o` follows it, and the waiting index is unchanged.
- R7: A resolve made while no prediction is waiting is ignored. The history and all counters are unchanged.
- R8: An accepted resolve changes only the counter that was used for the waiting prediction. Every other counter keeps its value.
- R9: On a repeating stream that interleaves an inner branch taken once every three iterations with an always-taken loop branch, the default 4-bit predictor makes no mispredictions once warmed up (after iteration 40 of 100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Request a direction for the next branch |
| resolve_i | input | 1 | Strobe: the waiting branch has resolved |
| resolve_taken_i | input | 1 | Real outcome with `resolve_i` (1 = taken) |
| pred_valid_o | output | 1 | High for one cycle when `pred_taken_o` carries a new prediction |
| pred_taken_o | output | 1 | Predicted direction (1 = taken), held until the next prediction |
| history_o | output | HIST_W | Current global outcome history, newest outcome in bit 0 |

## Verification
A long run of taken outcomes drives the history to all ones and walks one counter into its top state. A long run of not-taken outcomes does the same for the all-zero index and the bottom state. A later prediction on each index then shows saturation apart from wraparound. Back-to-back requests and stray resolves show that accepted and dropped handshakes differ. A request made in the same cycle as a resolve shows that the resolve takes priority. The interleaved two-branch loop pattern produces six distinct history windows. It checks that the history really selects separate counters, and that mispredictions stop after warm-up.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

    typedef logic [1:0] ctr_t;

    // reset value of every counter: weakly taken
    localparam ctr_t CTR_INIT = 2'b10;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == 2'b11) ? cur : cur + 2'b01;
        end else begin
            nxt = (cur == 2'b00) ? cur : cur - 2'b01;
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/ghp_history.sv
module ghp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.hist;

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (hist_o[0] == $past(bit_i)) &&
                    (hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])));

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(hist_o));

endmodule

// File: rtl/ghp_ctr_table.sv
module ghp_ctr_table
    import ghp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx_i,
    output ctr_t              rd_ctr_o,
    input  logic              upd_i,
    input  logic [HIST_W-1:0] upd_idx_i,
    input  logic              upd_taken_i
);

    localparam int N_ENT = 1 << HIST_W;

    ctr_t             ctr_d [N_ENT];
    ctr_t             ctr_q [N_ENT];
    logic [N_ENT-1:0] wr_en;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        always_comb begin
            wr_en[e] = upd_i && (upd_idx_i == HIST_W'(e));
            ctr_d[e] = ctr_q[e];
            if (wr_en[e]) begin
                ctr_d[e] = ctr_step(ctr_q[e], upd_taken_i);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctr_q[e] <= CTR_INIT;
            end else begin
                ctr_q[e] <= ctr_d[e];
            end
        end

        // R3
        sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[e] && upd_taken_i && ctr_q[e] == 2'b11) |=> ctr_q[e] == 2'b11);

        // R3
        sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[e] && !upd_taken_i && ctr_q[e] == 2'b00) |=> ctr_q[e] == 2'b00);

        // R8
        ent_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[e] |=> $stable(ctr_q[e]));
    end

    assign rd_ctr_o = ctr_q[rd_idx_i];

    // R8
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

endmodule

// File: rtl/ghist_dir_predictor.sv
module ghist_dir_predictor
    import ghp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_req_i,
    input  logic              resolve_i,
    input  logic              resolve_taken_i,
    output logic              pred_valid_o,
    output logic              pred_taken_o,
    output logic [HIST_W-1:0] history_o
);

    typedef struct packed {
        logic              pend;
        logic [HIST_W-1:0] idx;
        logic              valid;
        logic              taken;
    } ctl_state_t;

    ctl_state_t        st_d, st_q;
    logic              acc_req, acc_res;
    logic [HIST_W-1:0] hist;
    ctr_t              rd_ctr;

    ghp_history #(.HIST_W(HIST_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (acc_res),
        .bit_i   (resolve_taken_i),
        .hist_o  (hist)
    );

    ghp_ctr_table #(.HIST_W(HIST_W)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_i    (hist),
        .rd_ctr_o    (rd_ctr),
        .upd_i       (acc_res),
        .upd_idx_i   (st_q.idx),
        .upd_taken_i (resolve_taken_i)
    );

    always_comb begin
        acc_req  = pred_req_i && !st_q.pend;
        acc_res  = resolve_i && st_q.pend;
        st_d     = st_q;
        st_d.valid = acc_req;
        if (acc_req) begin
            st_d.idx   = hist;
            st_d.taken = ctr_says_taken(rd_ctr);
        end
        st_d.pend = acc_req || (st_q.pend && !acc_res);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_valid_o = st_q.valid;
    assign pred_taken_o = st_q.taken;
    assign history_o    = hist;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |=> !pred_valid_o);

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> $past(pred_req_i));

    // R6
    busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && pred_req_i) |=> !pred_valid_o);

    // R7
    idle_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && resolve_i) |=> history_o == $past(history_o));

endmodule

// File: tb/sim_ghist_dir_predictor.sv
module sim_ghist_dir_predictor;

    localparam int CLK_P = 10;
    localparam int HW    = 4;
    localparam int NENT  = 1 << HW;
    localparam int MASK  = NENT - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_req = 1'b0;
    logic          resolve = 1'b0;
    logic          res_taken = 1'b0;
    logic          pred_valid;
    logic          pred_taken;
    logic [HW-1:0] history;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_ctr [NENT];
    int m_hist = 0;
    int m_idx = 0;
    bit m_pend = 1'b0;
    bit e_valid = 1'b0;
    bit e_taken = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ghist_dir_predictor #(.HIST_W(HW)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .pred_req_i      (pred_req),
        .resolve_i       (resolve),
        .resolve_taken_i (res_taken),
        .pred_valid_o    (pred_valid),
        .pred_taken_o    (pred_taken),
        .history_o       (history)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive, advance the model, compare every output
    task automatic step(input string tag, input bit rq, input bit rs, input bit rt);
        bit acc_q, acc_r;
        @(negedge clk);
        pred_req  = rq;
        resolve   = rs;
        res_taken = rt;
        acc_q = rq && !m_pend;
        acc_r = rs && m_pend;
        if (acc_q) begin
            e_taken = (m_ctr[m_hist] >= 2);
            m_idx   = m_hist;
        end
        if (acc_r) begin
            if (rt && m_ctr[m_idx] < 3) m_ctr[m_idx]++;
            if (!rt && m_ctr[m_idx] > 0) m_ctr[m_idx]--;
            m_hist = ((m_hist << 1) | int'(rt)) & MASK;
        end
        m_pend  = acc_q || (m_pend && !acc_r);
        e_valid = acc_q;
        @(posedge clk);
        #(CLK_P/4);
        check({tag, "/R2 valid"}, int'(pred_valid), int'(e_valid));
        if (e_valid) check({tag, "/R5 direction"}, int'(pred_taken), int'(e_taken));
        check({tag, "/R4 history"}, int'(history), m_hist);
    endtask

    task automatic branch(input string tag, input bit outcome);
        step(tag, 1'b1, 1'b0, 1'b0);
        step(tag, 1'b0, 1'b1, outcome);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int late_miss;
        for (int e = 0; e < NENT; e++) m_ctr[e] = 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/4);
        // R1: reset state
        check("R1 history", int'(history), 0);
        check("R1 valid", int'(pred_valid), 0);
        step("R1", 1'b1, 1'b0, 1'b0);
        check("R1 first prediction", int'(pred_taken), 1);
        step("R4", 1'b0, 1'b1, 1'b1);
        check("R4 after one taken", int'(history), 1);
        branch("R4", 1'b1);
        check("R4 after two taken", int'(history), 3);

        // R7: stray resolves while idle
        step("R7", 1'b0, 1'b1, 1'b1);
        step("R7", 1'b0, 1'b1, 1'b0);
        check("R7 history kept", int'(history), 3);

        // R6: second request while waiting
        step("R6", 1'b1, 1'b0, 1'b0);
        step("R6", 1'b1, 1'b0, 1'b0);
        check("R6 no second valid", int'(pred_valid), 0);
        // request coinciding with resolve: resolve wins, request dropped
        step("R6", 1'b1, 1'b1, 1'b0);
        step("R6", 1'b0, 1'b0, 1'b0);
        check("R6 coincident request dropped", int'(pred_valid), 0);

        // R3: saturate counter 1111 at the top
        for (int k = 0; k < 8; k++) branch("R3", 1'b1);
        step("R3", 1'b1, 1'b0, 1'b0);
        check("R3 top saturation", int'(pred_taken), 1);
        step("R3", 1'b0, 1'b1, 1'b1);
        // R3/R8: saturate counter 0000 at the bottom
        for (int k = 0; k < 9; k++) branch("R3", 1'b0);
        step("R3", 1'b1, 1'b0, 1'b0);
        check("R3 bottom saturation", int'(pred_taken), 0);
        step("R3", 1'b0, 1'b1, 1'b0);
        check("R8 index 0000 kept", int'(history), 0);

        // R9: interleaved loop pattern
        late_miss = 0;
        for (int i = 0; i < 100; i++) begin
            bit y;
            y = (i % 3 == 0);
            step("R9", 1'b1, 1'b0, 1'b0);
            if (i >= 40 && pred_taken != y) late_miss++;
            step("R9", 1'b0, 1'b1, y);
            step("R9", 1'b1, 1'b0, 1'b0);
            if (i >= 40 && pred_taken != 1'b1) late_miss++;
            step("R9", 1'b0, 1'b1, 1'b1);
        end
        check("R9 late mispredictions", late_miss, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule